// File: doc/BRIEF.md
# UV-Erasable Byte Memory Control Model

A synthesizable, clocked behavioural model of a byte-wide, one-time-writable memory that can be fully cleared by an erase strobe standing in for ultraviolet exposure. The depth is a parameter. Each cycle the block decodes the active-low chip-select/program line, the active-low output enable and two supply-level flags into one of six operating modes. It reports the mode, drives the data bus with a separate enable, and applies writes that can only turn stored 1s into 0s.

An identification flag models a high voltage on one address line. In read mode it replaces array data with a two-byte code that is selected by address bit 0. Analog levels, access-time delays and power are not modelled. A program pulse is represented by chip-select/program going low for one or more cycles and then rising. The write commits on the clock edge at which the rise is seen.

Top module: `uv_eprom_model`

## Requirements
- R1: Read mode (code 0): with the programming supply absent, chip-select/program low and output enable low, `dout_en` is 1 and `dout` shows the byte stored at `addr` in the same cycle.
- R2: Standby (code 2): with the programming supply absent and chip-select/program high, `dout_en` is 0 for either level of output enable.
- R3: Output disable (code 1): with the programming supply absent, chip-select/program low and output enable high, `dout_en` is 0.
- R4: Program (code 3): with the programming supply present, output enable high and chip-select/program low, `dout_en` is 0. `addr` and `din` are captured. When chip-select/program is next seen high at a clock edge, the captured location becomes its old value AND the captured data.
- R5: Inhibit (code 5): with the programming supply present, output enable high and chip-select/program high, `dout_en` is 0. No write occurs unless the previous cycle was in program mode.
- R6: Verify (code 4): with the programming supply present and output enable low, `dout_en` is 1 and `dout` shows the stored array byte. The identification flag is ignored in this mode.
- R7: After reset every location reads 0xFF. A write never turns a stored 0 into a 1.
- R8: In read mode with `id_hv` set, `dout` is 0x8F when `addr[0]` is 0 and 0x08 when `addr[0]` is 1.
- R9: An `erase` pulse sets every location to 0xFF at the next clock edge. It has no effect while the programming supply is present.
- R10: The programming supply is present only when both `vpp_hi` and `vcc_hi` are 1. With `vcc_hi` 0, the normal-supply modes apply.
- R11: While `dout_en` is 0, `dout` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; blanks the array |
| addr | input | ADDR_W | Byte address |
| ce_pgm_n | input | 1 | Chip select and program pulse, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming voltage raised |
| vcc_hi | input | 1 | Core supply raised for programming |
| id_hv | input | 1 | High voltage on identification address line |
| erase | input | 1 | Bulk erase strobe |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not driven |
| dout_en | output | 1 | Data bus drive enable |
| mode | output | 3 | Operating mode code |

## Verification
The hardest situation to reach is a write that should be refused. Two such cases exist. One is an inhibit cycle entered without a preceding program cycle. The other is a low pulse on chip-select/program while only one of the two supply flags is raised. Neither refusal shows anything at the outputs while it happens. The stimulus therefore first programs a known pattern into a location. It then applies the refused write with data of all zeros, and returns to read mode on the same address. An accepted write would have visibly cleared bits. The same pattern checks that erase is blocked under the programming supply.

// File: rtl/uv_eprom_model.sv
module uv_eprom_model #(
  parameter int ADDR_W = 6,
  parameter logic [7:0] MFG_CODE = 8'h8F,
  parameter logic [7:0] DEV_CODE = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_pgm_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              vcc_hi,
  input  logic              id_hv,
  input  logic              erase,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic [2:0]        mode
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [2:0] M_READ = 3'd0, M_ODIS = 3'd1, M_STBY = 3'd2,
                         M_PROG = 3'd3, M_VRFY = 3'd4, M_INHB = 3'd5;

  logic [7:0]        mem [DEPTH];
  logic              armed;
  logic [ADDR_W-1:0] wa;
  logic [7:0]        wd;
  logic              prog_sup;
  logic              commit;
  logic              wipe;
  logic [7:0]        rd_byte;

  assign prog_sup = vpp_hi & vcc_hi;
  assign commit   = armed & ce_pgm_n;
  assign wipe     = erase & ~prog_sup;

  always_comb begin
    if (prog_sup)      mode = !oe_n ? M_VRFY : (ce_pgm_n ? M_INHB : M_PROG);
    else if (ce_pgm_n) mode = M_STBY;
    else               mode = oe_n ? M_ODIS : M_READ;
  end

  assign rd_byte = (mode == M_READ && id_hv) ? (addr[0] ? DEV_CODE : MFG_CODE) : mem[addr];
  assign dout_en = (mode == M_READ) || (mode == M_VRFY);
  assign dout    = dout_en ? rd_byte : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      wa    <= '0;
      wd    <= 8'hFF;
    end else begin
      armed <= (mode == M_PROG);
      if (mode == M_PROG) begin
        wa <= addr;
        wd <= din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (wipe) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      mem[wa] <= mem[wa] & wd;
    end
  end

  logic [7:0] old_byte;
  assign old_byte = mem[wa];

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!(vpp_hi && vcc_hi) && ce_pgm_n) |-> !dout_en); // R2
  AST_PROG_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && vcc_hi && oe_n) |-> !dout_en); // R4
  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wipe) |=> ((mem[$past(wa)] & ~$past(old_byte)) == 8'h00)); // R7
  AST_ERASE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (erase && !(vpp_hi && vcc_hi)) |=> (mem[$past(addr)] == 8'hFF)); // R9
  AST_ID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && id_hv && !vpp_hi && !addr[0]) |-> (dout == MFG_CODE)); // R8
  AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == 8'h00)); // R11
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= M_INHB); // R10
endmodule

// File: tb/tb_uv_eprom_model.sv
module tb_uv_eprom_model;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic ce_pgm_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, vcc_hi = 1'b0, id_hv = 1'b0, erase = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en;
  logic [2:0] mode;

  always #2.5 clk = ~clk;

  uv_eprom_model dut (.clk(clk), .rst_n(rst_n), .addr(addr), .ce_pgm_n(ce_pgm_n), .oe_n(oe_n),
    .vpp_hi(vpp_hi), .vcc_hi(vcc_hi), .id_hv(id_hv), .erase(erase), .din(din),
    .dout(dout), .dout_en(dout_en), .mode(mode));

  typedef struct { logic chk; logic en; logic [7:0] d; logic [2:0] m; string tag; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  task automatic step(input logic [5:0] a, input logic ce, input logic oe, input logic vp,
                      input logic vc, input logic id, input logic er, input logic [7:0] wdat,
                      input logic chk, input logic een, input logic [7:0] ed,
                      input logic [2:0] em, input string tag);
    exp_t e;
    @(posedge clk); #1;
    addr = a; ce_pgm_n = ce; oe_n = oe; vpp_hi = vp; vcc_hi = vc; id_hv = id; erase = er; din = wdat;
    e.chk = chk; e.en = een; e.d = ed; e.m = em; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.chk) begin
        total++;
        if (dout_en !== e.en || dout !== e.d || mode !== e.m) begin
          bad++;
          $display("FAIL %s: got en=%0b d=%02h m=%0d exp en=%0b d=%02h m=%0d",
                   e.tag, dout_en, dout, mode, e.en, e.d, e.m);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state: blank, read mode
    step(3, 0,0, 0,0, 0,0, 8'h00, 1, 1, 8'hFF, 0, "R7 reset blank read");
    step(3, 0,0, 0,0, 0,0, 8'h00, 1, 1, 8'hFF, 0, "R1 read mode");
    step(3, 1,0, 0,0, 0,0, 8'h00, 1, 0, 8'h00, 2, "R2 standby oe low");
    step(3, 1,1, 0,0, 0,0, 8'h00, 1, 0, 8'h00, 2, "R2 standby oe high");
    step(3, 0,1, 0,0, 0,0, 8'h00, 1, 0, 8'h00, 1, "R3 output disable R11");
    // program A5 into 3
    step(3, 0,1, 1,1, 0,0, 8'hA5, 1, 0, 8'h00, 3, "R4 program mode");
    step(3, 1,1, 1,1, 0,0, 8'hA5, 1, 0, 8'h00, 5, "R5 inhibit after pulse");
    step(3, 0,0, 0,0, 0,0, 8'h00, 1, 1, 8'hA5, 0, "R4 written value");
    step(4, 0,0, 0,0, 0,0, 8'h00, 1, 1, 8'hFF, 0, "R1 other address untouched");
    // second program: AND
    step(3, 0,1, 1,1, 0,0, 8'h0F, 0, 0, 8'h00, 3, "");
    step(3, 0,1, 1,1, 0,0, 8'h0F, 0, 0, 8'h00, 3, "");
    step(3, 1,1, 1,1, 0,0, 8'h00, 0, 0, 8'h00, 5, "");
    step(3, 1,0, 1,1, 1,0, 8'h00, 1, 1, 8'h05, 4, "R6 verify AND result R7");
    // inhibit without program: no write
    step(3, 1,1, 1,1, 0,0, 8'h00, 1, 0, 8'h00, 5, "R5 inhibit idle");
    step(3, 1,1, 1,1, 0,0, 8'h00, 0, 0, 8'h00, 5, "");
    step(3, 0,0, 0,0, 0,0, 8'h00, 1, 1, 8'h05, 0, "R5 no write from inhibit");
    // try to set bits back to 1
    step(3, 0,1, 1,1, 0,0, 8'hFF, 0, 0, 8'h00, 3, "");
    step(3, 1,1, 1,1, 0,0, 8'hFF, 0, 0, 8'h00, 5, "");
    step(3, 0,0, 0,0, 0,0, 8'h00, 1, 1, 8'h05, 0, "R7 ones cannot return");
    // vcc low: not programming supply
    step(3, 0,1, 1,0, 0,0, 8'h00, 1, 0, 8'h00, 1, "R10 vpp only is output disable");
    step(3, 1,1, 1,0, 0,0, 8'h00, 1, 0, 8'h00, 2, "R10 vpp only standby");
    step(3, 0,0, 0,0, 0,0, 8'h00, 1, 1, 8'h05, 0, "R10 no write without vcc flag");
    // identification
    step(2, 0,0, 0,0, 1,0, 8'h00, 1, 1, 8'h8F, 0, "R8 manufacturer code");
    step(3, 0,0, 0,0, 1,0, 8'h00, 1, 1, 8'h08, 0, "R8 device code");
    step(3, 1,1, 0,0, 1,0, 8'h00, 1, 0, 8'h00, 2, "R8 R11 id in standby hidden");
    // erase blocked under supply
    step(3, 1,1, 1,1, 0,1, 8'h00, 1, 0, 8'h00, 5, "R9 erase under supply");
    step(3, 0,0, 0,0, 0,0, 8'h00, 1, 1, 8'h05, 0, "R9 erase blocked");
    step(3, 1,1, 0,0, 0,1, 8'h00, 1, 0, 8'h00, 2, "R9 erase strobe");
    step(3, 0,0, 0,0, 0,0, 8'h00, 1, 1, 8'hFF, 0, "R9 erased");
    step(0, 1,1, 0,0, 0,0, 8'h00, 0, 0, 8'h00, 2, "");
    @(posedge clk); @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule